// File: doc/BRIEF.md
# Generalized Bit-Reverse Execution Unit

This unit executes the generalized reverse operation of a 64-bit scalar core. Result bit j is taken from operand bit j XOR k, where k is a control value. The datapath is a cascade of butterfly swap stages. Stage s exchanges neighbouring groups of 2^s bits, and it acts only when bit s of the control value is set. Some control values give familiar operations: k = 63 reverses every bit, and k = 56 reverses the byte order.

The unit decodes a 32-bit instruction word itself and accepts four forms: a register form and an immediate form on the full 64-bit word, and matching word forms on the low 32 bits. The word forms clear the upper half of the operand, apply the reverse, and sign-extend bit 31 of the outcome. A word-immediate whose shift amount is 32 or more is flagged as illegal and produces no result. An instruction word that belongs to none of the four forms is left alone, so that a neighbouring unit can claim it. By default an output register gives one cycle of latency, and a new operation can be issued every cycle.

Top module: `grev_unit`

## Requirements
- R1: While rst_n is low, out_valid, out_illegal and out_result are all zero.
- R2: The 64-bit register form is identified by instr[31:25]=0110100, instr[14:12]=101 and instr[6:0]=0110011. Its control value is src_b[5:0], and out_result bit j equals src_a bit (j XOR k). The upper bits of src_b have no effect.
- R3: The 64-bit immediate form is identified by instr[31:26]=011010, instr[14:12]=101 and instr[6:0]=0010011. Its control value is instr[25:20], and the result follows the rule of R2.
- R4: An immediate-form control value of 56 returns src_a with its eight bytes in reverse order.
- R5: The word register form is identified by instr[31:25]=0110100, instr[14:12]=101 and instr[6:0]=0111011. Its control value is src_b[4:0]. For j < 32, out_result bit j equals src_a bit (j XOR k), and bits 63:32 all copy bit 31. src_a[63:32] has no effect.
- R6: The word immediate form is identified by instr[31:26]=011010, instr[14:12]=101 and instr[6:0]=0011011, with instr[25]=0. Its control value is instr[24:20], and the result follows the rule of R5.
- R7: A word immediate form whose shift amount instr[25:20] is 32 or more raises out_illegal. out_valid stays low and out_result is zero.
- R8: When in_valid is low, or the instruction word matches none of the four forms, out_valid and out_illegal are low and out_result is zero.
- R9: Each accepted instruction is reported in the first cycle after the clock edge that samples it. Operations issued in consecutive cycles each produce their own result.
- R10: Every result is a permutation of its operand. A 64-bit form keeps the count of ones of src_a, and a word form keeps the count of ones of src_a[31:0] in out_result[31:0].

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Instruction and operands present this cycle |
| instr | input | 32 | Instruction word |
| src_a | input | 64 | Operand to be permuted |
| src_b | input | 64 | Second operand, source of the control value in the register forms |
| out_valid | output | 1 | out_result holds a result |
| out_illegal | output | 1 | Word immediate with an out-of-range shift amount |
| out_result | output | 64 | Permuted value, sign-extended for word forms |

## Verification
Two functions meet in the same cycle when an illegal word immediate arrives. The decoder's rejection and the butterfly network's output for the same operands reach the output stage together, and the rejection must win: the flag is set and the result is forced to zero. The bench provokes this in two ways. It sweeps every word-immediate shift amount from 0 to 63 with no idle cycles between operations, and it runs a mixed stream of legal, illegal and foreign words back to back. A result or flag from one operation must not leak into the one after it. Expected values come from the rule "output bit j takes operand bit j XOR k", which is computed independently of the stage structure.

// File: rtl/grev_pkg.sv
package grev_pkg;

  localparam int unsigned MASK_W = 64;

  localparam logic [6:0] OPC_ARITH   = 7'b0110011;
  localparam logic [6:0] OPC_ARITH_I = 7'b0010011;
  localparam logic [6:0] OPC_WORD    = 7'b0111011;
  localparam logic [6:0] OPC_WORD_I  = 7'b0011011;
  localparam logic [6:0] F7_GREV     = 7'b0110100;
  localparam logic [5:0] F6_GREV     = 6'b011010;
  localparam logic [2:0] F3_GREV     = 3'b101;

  typedef enum logic [2:0] {
    FORM_NONE,
    FORM_FULL_REG,
    FORM_FULL_IMM,
    FORM_WORD_REG,
    FORM_WORD_IMM,
    FORM_BAD_IMM
  } grev_form_e;

  // Mask that selects the lower group of each pair of 2^s-bit groups.
  function automatic logic [MASK_W-1:0] lane_mask(int unsigned s);
    logic [MASK_W-1:0] m;
    for (int unsigned b = 0; b < MASK_W; b++) begin
      m[b] = (((b >> s) & 1) == 0);
    end
    return m;
  endfunction

endpackage

// File: rtl/grev_decode.sv
module grev_decode
  import grev_pkg::*;
#(
  parameter int XW  = 64,
  parameter int WW  = 32,
  parameter int NS  = $clog2(XW),
  parameter int NSW = $clog2(WW)
) (
  input  logic            in_valid,
  input  logic [31:0]     instr,
  input  logic [NS-1:0]   ctrl_reg,
  output grev_form_e      form,
  output logic [3:0]      form_hits,
  output logic            hit,
  output logic            illegal,
  output logic            word,
  output logic [NS-1:0]   ctrl
);

  logic       f3_ok;
  logic       f7_ok;
  logic       f6_ok;
  logic [5:0] shamt;
  logic       shamt_wide;
  logic       m_full_reg;
  logic       m_full_imm;
  logic       m_word_reg;
  logic       m_word_imm;
  logic       unused_fields;

  assign f3_ok = (instr[14:12] == F3_GREV);
  assign f7_ok = (instr[31:25] == F7_GREV);
  assign f6_ok = (instr[31:26] == F6_GREV);
  assign shamt = instr[25:20];
  assign shamt_wide = (int'(shamt) >= WW);

  assign m_full_reg = f7_ok && f3_ok && (instr[6:0] == OPC_ARITH);
  assign m_full_imm = f6_ok && f3_ok && (instr[6:0] == OPC_ARITH_I);
  assign m_word_reg = f7_ok && f3_ok && (instr[6:0] == OPC_WORD);
  assign m_word_imm = f6_ok && f3_ok && (instr[6:0] == OPC_WORD_I);

  assign form_hits = {m_word_imm, m_word_reg, m_full_imm, m_full_reg};
  assign unused_fields = ^{instr[19:15], instr[11:7]};

  always_comb begin
    form = FORM_NONE;
    if (in_valid) begin
      unique case (1'b1)
        m_full_reg: form = FORM_FULL_REG;
        m_full_imm: form = FORM_FULL_IMM;
        m_word_reg: form = FORM_WORD_REG;
        m_word_imm: form = shamt_wide ? FORM_BAD_IMM : FORM_WORD_IMM;
        default:    form = FORM_NONE;
      endcase
    end
  end

  always_comb begin
    ctrl = '0;
    unique case (form)
      FORM_FULL_REG: ctrl = ctrl_reg;
      FORM_FULL_IMM: ctrl = shamt[NS-1:0];
      FORM_WORD_REG: ctrl = NS'(ctrl_reg[NSW-1:0]);
      FORM_WORD_IMM: ctrl = NS'(shamt[NSW-1:0]);
      default:       ctrl = '0;
    endcase
  end

  assign hit     = (form == FORM_FULL_REG) || (form == FORM_FULL_IMM) ||
                   (form == FORM_WORD_REG) || (form == FORM_WORD_IMM);
  assign illegal = (form == FORM_BAD_IMM);
  assign word    = (form == FORM_WORD_REG) || (form == FORM_WORD_IMM);

endmodule

// File: rtl/grev_network.sv
module grev_network #(
  parameter int W  = 64,
  parameter int NS = $clog2(W)
) (
  input  logic [W-1:0]  din,
  input  logic [NS-1:0] ctrl,
  output logic [W-1:0]  dout
);

  function automatic logic [W-1:0] butterfly(logic [W-1:0] x, logic [W-1:0] m,
                                             int unsigned sh);
    return ((x & m) << sh) | ((x & ~m) >> sh);
  endfunction

  logic [W-1:0] lvl [NS+1];

  assign lvl[0] = din;

  for (genvar s = 0; s < NS; s++) begin : g_stage
    localparam logic [W-1:0] LANE = W'(grev_pkg::lane_mask(s));
    localparam int unsigned  DIST = 1 << s;
    assign lvl[s+1] = ctrl[s] ? butterfly(lvl[s], LANE, DIST) : lvl[s];
  end

  assign dout = lvl[NS];

endmodule

// File: rtl/grev_outreg.sv
module grev_outreg #(
  parameter int XW      = 64,
  parameter bit OUT_REG = 1'b1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          d_valid,
  input  logic          d_illegal,
  input  logic          d_word,
  input  logic [XW-1:0] d_result,
  output logic          q_valid,
  output logic          q_illegal,
  output logic          q_word,
  output logic [XW-1:0] q_result
);

  if (OUT_REG) begin : g_reg
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        q_valid   <= 1'b0;
        q_illegal <= 1'b0;
        q_word    <= 1'b0;
        q_result  <= '0;
      end else begin
        q_valid   <= d_valid;
        q_illegal <= d_illegal;
        q_word    <= d_word;
        q_result  <= d_result;
      end
    end
  end else begin : g_pass
    assign q_valid   = d_valid;
    assign q_illegal = d_illegal;
    assign q_word    = d_word;
    assign q_result  = d_result;
  end

endmodule

// File: rtl/grev_unit.sv
module grev_unit
  import grev_pkg::*;
#(
  parameter int XW      = 64,
  parameter int WW      = 32,
  parameter bit OUT_REG = 1'b1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  input  logic [31:0]   instr,
  input  logic [XW-1:0] src_a,
  input  logic [XW-1:0] src_b,
  output logic          out_valid,
  output logic          out_illegal,
  output logic [XW-1:0] out_result
);

  localparam int NS  = $clog2(XW);
  localparam int NSW = $clog2(WW);

  grev_form_e    dec_form;
  logic [3:0]    dec_hits;
  logic          dec_hit;
  logic          dec_illegal;
  logic          dec_word;
  logic [NS-1:0] dec_ctrl;
  logic [XW-1:0] net_in;
  logic [XW-1:0] net_out;
  logic [XW-1:0] fin_result;
  logic [XW-1:0] gated_result;
  logic          q_word;
  logic          unused_b;

  assign unused_b = ^src_b[XW-1:NS];

  grev_decode #(.XW(XW), .WW(WW), .NS(NS), .NSW(NSW)) u_dec (
    .in_valid  (in_valid),
    .instr     (instr),
    .ctrl_reg  (src_b[NS-1:0]),
    .form      (dec_form),
    .form_hits (dec_hits),
    .hit       (dec_hit),
    .illegal   (dec_illegal),
    .word      (dec_word),
    .ctrl      (dec_ctrl)
  );

  // Word forms see only the low half of the operand.
  assign net_in = dec_word ? {{(XW-WW){1'b0}}, src_a[WW-1:0]} : src_a;

  grev_network #(.W(XW), .NS(NS)) u_net (
    .din  (net_in),
    .ctrl (dec_ctrl),
    .dout (net_out)
  );

  assign fin_result   = dec_word ? {{(XW-WW){net_out[WW-1]}}, net_out[WW-1:0]} : net_out;
  assign gated_result = dec_hit ? fin_result : '0;

  grev_outreg #(.XW(XW), .OUT_REG(OUT_REG)) u_out (
    .clk       (clk),
    .rst_n     (rst_n),
    .d_valid   (dec_hit),
    .d_illegal (dec_illegal),
    .d_word    (dec_word),
    .d_result  (gated_result),
    .q_valid   (out_valid),
    .q_illegal (out_illegal),
    .q_word    (q_word),
    .q_result  (out_result)
  );

endmodule

// File: rtl/grev_unit_chk.sv
module grev_unit_chk #(
  parameter int XW      = 64,
  parameter int WW      = 32,
  parameter bit OUT_REG = 1'b1
) (
  input logic          clk,
  input logic          rst_n,
  input logic          in_valid,
  input logic [XW-1:0] src_a,
  input logic [3:0]    dec_hits,
  input logic          q_word,
  input logic          out_valid,
  input logic          out_illegal,
  input logic [XW-1:0] out_result
);

  logic          seen_valid;
  logic [XW-1:0] seen_src;

  if (OUT_REG) begin : g_delay
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        seen_valid <= 1'b0;
        seen_src   <= '0;
      end else begin
        seen_valid <= in_valid;
        seen_src   <= src_a;
      end
    end
  end else begin : g_now
    assign seen_valid = in_valid;
    assign seen_src   = src_a;
  end

  AST_ONE_FORM: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(dec_hits)); // R2

  AST_FLAGS_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    !(out_valid && out_illegal)); // R7

  AST_ILLEGAL_NO_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    out_illegal |-> (out_result == '0)); // R7

  AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> (out_result == '0)); // R8

  AST_NEEDS_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid || out_illegal) |-> seen_valid); // R9

  AST_WORD_SIGN: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && q_word) |-> (out_result[XW-1:WW] == {(XW-WW){out_result[WW-1]}})); // R5

  AST_ONES_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !q_word) |-> ($countones(out_result) == $countones(seen_src))); // R10

  AST_ONES_WORD: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && q_word) |->
      ($countones(out_result[WW-1:0]) == $countones(seen_src[WW-1:0]))); // R10

endmodule

bind grev_unit grev_unit_chk #(.XW(XW), .WW(WW), .OUT_REG(OUT_REG)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .in_valid    (in_valid),
  .src_a       (src_a),
  .dec_hits    (dec_hits),
  .q_word      (q_word),
  .out_valid   (out_valid),
  .out_illegal (out_illegal),
  .out_result  (out_result)
);

// File: tb/grev_unit_test.sv
module grev_unit_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [31:0] instr = '0;
  logic [63:0] src_a = '0;
  logic [63:0] src_b = '0;
  logic        out_valid;
  logic        out_illegal;
  logic [63:0] out_result;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;

  grev_unit uut (
    .clk (clk), .rst_n (rst_n), .in_valid (in_valid), .instr (instr),
    .src_a (src_a), .src_b (src_b), .out_valid (out_valid),
    .out_illegal (out_illegal), .out_result (out_result)
  );

  function automatic logic [31:0] enc_r(logic [6:0] f7, logic [2:0] f3, logic [6:0] opc);
    return {f7, 5'd2, 5'd1, f3, 5'd3, opc};
  endfunction

  function automatic logic [31:0] enc_i(logic [5:0] f6, logic [5:0] sh, logic [2:0] f3,
                                        logic [6:0] opc);
    return {f6, sh, 5'd1, f3, 5'd3, opc};
  endfunction

  function automatic logic [63:0] ref_full(logic [63:0] a, int k);
    logic [63:0] r;
    for (int j = 0; j < 64; j++) r[j] = a[j ^ k];
    return r;
  endfunction

  function automatic logic [63:0] ref_word(logic [63:0] a, int k);
    logic [31:0] w;
    for (int j = 0; j < 32; j++) w[j] = a[j ^ k];
    return {{32{w[31]}}, w};
  endfunction

  function automatic logic [63:0] ref_bytes(logic [63:0] a);
    logic [63:0] r;
    for (int i = 0; i < 8; i++) r[8*i +: 8] = a[8*(7-i) +: 8];
    return r;
  endfunction

  task automatic step(input logic v, input logic [31:0] ins, input logic [63:0] a,
                      input logic [63:0] b, input logic ev, input logic ei,
                      input logic [63:0] er, input string req);
    in_valid = v; instr = ins; src_a = a; src_b = b;
    @(negedge clk);
    n_chk++;
    if (out_valid !== ev || out_illegal !== ei || out_result !== er) begin
      n_fail++;
      $display("FAIL %s: got valid=%b illegal=%b result=%h, expected valid=%b illegal=%b result=%h",
               req, out_valid, out_illegal, out_result, ev, ei, er);
    end
  endtask

  initial begin
    logic [63:0] pats [4];
    logic [31:0] r_full, r_word;
    logic [31:0] foreign [7];
    pats[0] = 64'h0123_4567_89AB_CDEF;
    pats[1] = 64'h8000_0000_0000_0001;
    pats[2] = 64'hF0F0_1234_5678_9A5C;
    pats[3] = {$urandom, $urandom};
    r_full = enc_r(7'b0110100, 3'b101, 7'b0110011);
    r_word = enc_r(7'b0110100, 3'b101, 7'b0111011);

    // R1: reset state
    repeat (3) @(negedge clk);
    n_chk++;
    if (out_valid !== 1'b0 || out_illegal !== 1'b0 || out_result !== 64'h0) begin
      n_fail++;
      $display("FAIL R1: got valid=%b illegal=%b result=%h, expected 0 0 0",
               out_valid, out_illegal, out_result);
    end
    rst_n = 1'b1;
    @(negedge clk);

    // R2: full register form, upper src_b bits carry noise
    for (int p = 0; p < 4; p++)
      for (int k = 0; k < 64; k++)
        step(1'b1, r_full, pats[p], {$urandom, $urandom} & ~64'h3F | 64'(k),
             1'b1, 1'b0, ref_full(pats[p], k), "R2");

    // R3: full immediate form
    for (int p = 0; p < 2; p++)
      for (int k = 0; k < 64; k++)
        step(1'b1, enc_i(6'b011010, 6'(k), 3'b101, 7'b0010011), pats[p], '0,
             1'b1, 1'b0, ref_full(pats[p], k), "R3");

    // R4: byte reversal
    for (int p = 0; p < 4; p++)
      step(1'b1, enc_i(6'b011010, 6'd56, 3'b101, 7'b0010011), pats[p], '0,
           1'b1, 1'b0, ref_bytes(pats[p]), "R4");

    // R5: word register form, noise in upper halves of both operands
    for (int p = 0; p < 4; p++)
      for (int k = 0; k < 32; k++)
        step(1'b1, r_word, pats[p] ^ {32'hDEAD_BEEF, 32'h0},
             {$urandom, $urandom} & ~64'h1F | 64'(k),
             1'b1, 1'b0, ref_word(pats[p], k), "R5");

    // R6 and R7: every word-immediate shift amount, back to back
    for (int p = 0; p < 3; p++)
      for (int k = 0; k < 64; k++) begin
        if (k < 32)
          step(1'b1, enc_i(6'b011010, 6'(k), 3'b101, 7'b0011011), pats[p], '1,
               1'b1, 1'b0, ref_word(pats[p], k), "R6");
        else
          step(1'b1, enc_i(6'b011010, 6'(k), 3'b101, 7'b0011011), pats[p], '1,
               1'b0, 1'b1, 64'h0, "R7");
      end

    // R8: foreign words and idle strobe
    foreign[0] = enc_r(7'b0110000, 3'b101, 7'b0110011);
    foreign[1] = enc_r(7'b0110100, 3'b001, 7'b0110011);
    foreign[2] = enc_r(7'b0110100, 3'b101, 7'b0110111);
    foreign[3] = enc_i(6'b011011, 6'd3, 3'b101, 7'b0010011);
    foreign[4] = enc_i(6'b010010, 6'd3, 3'b101, 7'b0010011);
    foreign[5] = enc_r(7'b0110100, 3'b101, 7'b0010111);
    foreign[6] = enc_i(6'b011010, 6'd40, 3'b100, 7'b0011011);
    for (int i = 0; i < 7; i++)
      step(1'b1, foreign[i], pats[0], 64'd5, 1'b0, 1'b0, 64'h0, "R8");
    step(1'b0, r_full, pats[0], 64'd5, 1'b0, 1'b0, 64'h0, "R8");

    // R9: mixed stream with no idle cycles
    step(1'b1, r_full, pats[2], 64'd63, 1'b1, 1'b0, ref_full(pats[2], 63), "R9");
    step(1'b1, enc_i(6'b011010, 6'd33, 3'b101, 7'b0011011), pats[2], '0,
         1'b0, 1'b1, 64'h0, "R9");
    step(1'b1, r_word, pats[1], 64'd31, 1'b1, 1'b0, ref_word(pats[1], 31), "R9");
    step(1'b1, foreign[0], pats[1], 64'd31, 1'b0, 1'b0, 64'h0, "R9");
    step(1'b1, r_full, pats[1], 64'd0, 1'b1, 1'b0, pats[1], "R9");
    step(1'b0, '0, '0, '0, 1'b0, 1'b0, 64'h0, "R9");

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

endmodule